// File: doc/BRIEF.md
# Three-wire serial register port

This block is the slave side of a serial register port in a sensor. A master drives a serial clock and an active-low select line, and shares one bidirectional data line with the slave. The data line is modelled as a separate input, output and output enable, and the analog pad lies outside the block. Each frame is two bytes long. The first byte carries a direction flag in its top bit and a 7-bit register address. The second byte is either the write data from the master or the read data from the slave. Register contents stay outside the block. A simple internal bus carries a one-cycle read or write strobe, an address and write data, and returns read data combinationally on a read-data input.

All serial inputs are resynchronised into the system clock domain and their edges are detected there. The slave samples the data line on rising serial-clock edges. It updates its output on falling edges, so each bit stays valid through the following rising edge. When select is released, the frame in progress is dropped and the port waits for a new address.

A read of one dedicated command address starts a burst. The burst streams a fixed run of seven consecutive motion registers with no further address bytes. After the run ends, the last register repeats. The port then stays locked in burst until select is released.

Top module: `sio_port`

## Requirements
- R1: After reset the output enable is low and no read or write strobe is issued.
- R2: A frame whose first bit is 1 is a write. Address bits and data bits are both taken MSB first on rising clock edges. Exactly one single-cycle write strobe, carrying the 7-bit address and the data byte, is issued on the 16th rising edge and never earlier. The read strobe stays low throughout the frame.
- R3: A frame whose first bit is 0 is a read. One read strobe, carrying the address, is issued on the 8th rising edge, and the returned byte is loaded at that moment. The byte is shifted out MSB first. Each bit appears after a falling edge and is held until the next falling edge.
- R4: The output enable is low during the address byte. It is high from the first falling edge after a read address until the falling edge that follows the end of the data byte. It drops as soon as select is high.
- R5: Raising select part way through a frame discards the frame and issues no write. The next frame is decoded from its first bit as an address.
- R6: While select is high, clock and data activity issues no strobe and leaves the output enable low.
- R7: A read of address 0x63 returns the registers at 0x03, 0x04, 0x05, 0x06, 0x07, 0x08 and 0x09, one byte each, in that order and with no address bytes between them.
- R8: Once the seventh burst byte has been sent, every further byte in the burst returns the register at 0x09.
- R9: During a burst, no bit pattern on the data line produces a write strobe or a new address. Normal frames resume after select has been released. A read strobe and a write strobe are never issued in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock from the master |
| sel_n_i | input | 1 | Active-low select from the master |
| sdio_i | input | 1 | Data line as seen by the slave |
| sdio_o | output | 1 | Data line value driven by the slave |
| sdio_oe_o | output | 1 | Slave drives the data line when high |
| reg_rd_o | output | 1 | One-cycle register read strobe |
| reg_wr_o | output | 1 | One-cycle register write strobe |
| reg_addr_o | output | 7 | Register address for either strobe |
| reg_wdata_o | output | 8 | Write data, valid with the write strobe |
| reg_rdata_i | input | 8 | Read data, valid in the cycle of the read strobe |

## Verification
Several properties are checked by assertions on every cycle. Strobes occur only on a detected rising edge, and a write strobe lasts exactly one cycle. Read and write strobes are mutually exclusive. The output enable is low whenever select is high. While the slave drives the line, its output changes only right after a falling edge. Other behaviours need whole frames and can only be shown by the bench's scenarios: address decoding across every address, correct data values, the burst order and the repeat of its last register, the burst lock-out, and recovery after an aborted frame.

// File: rtl/sio_pkg.sv
package sio_pkg;
  typedef enum logic [1:0] {
    PH_ADDR  = 2'd0,
    PH_WDATA = 2'd1,
    PH_RDATA = 2'd2,
    PH_BURST = 2'd3
  } phase_e;
endpackage

// File: rtl/sio_sync.sv
module sio_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic sel_n_i,
  input  logic sdio_i,
  output logic rise_o,
  output logic fall_o,
  output logic active_o,
  output logic sdio_o
);
  // bundle order {sclk, sel_n, sdio}; idle levels avoid false edges out of reset
  localparam logic [2:0] IDLE_V = 3'b110;

  logic [STAGES-1:0][2:0] stg;
  logic                   sclk_q;
  logic [2:0]             last_w;

  assign last_w = stg[STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg    <= {STAGES{IDLE_V}};
      sclk_q <= 1'b1;
    end else begin
      stg    <= {stg[STAGES-2:0], {sclk_i, sel_n_i, sdio_i}};
      sclk_q <= last_w[2];
    end
  end

  assign rise_o   = last_w[2] & ~sclk_q;
  assign fall_o   = ~last_w[2] & sclk_q;
  assign active_o = ~last_w[1];
  assign sdio_o   = last_w[0];
endmodule

// File: rtl/sio_frame.sv
module sio_frame
  import sio_pkg::*;
#(
  parameter int          DATA_W      = 8,
  parameter int          BURST_LEN   = 7,
  parameter logic [6:0]  BURST_CMD   = 7'h63,
  parameter logic [6:0]  BURST_FIRST = 7'h03,
  localparam int         ADDR_W      = DATA_W - 1,
  localparam int         CNT_W       = $clog2(DATA_W),
  localparam int         IDX_W       = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic              rise_i,
  input  logic              sdio_i,
  output phase_e            phase_o,
  output logic              rd_o,
  output logic              wr_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o
);
  phase_e            ph;
  logic [CNT_W-1:0]  bcnt;
  logic [DATA_W-1:0] shin;
  logic [ADDR_W-1:0] waddr;
  logic [IDX_W-1:0]  bidx;
  logic [IDX_W-1:0]  nidx;
  logic [DATA_W-1:0] byte_w;
  logic              last_bit;
  logic              is_wr;
  logic              is_burst;

  assign byte_w   = {shin[DATA_W-2:0], sdio_i};
  assign last_bit = active_i && rise_i && (bcnt == CNT_W'(DATA_W-1));
  assign is_wr    = byte_w[DATA_W-1];
  assign is_burst = !is_wr && (byte_w[ADDR_W-1:0] == ADDR_W'(BURST_CMD));
  // burst index saturates on the last register of the run
  assign nidx     = (bidx == IDX_W'(BURST_LEN-1)) ? bidx : bidx + 1'b1;

  always_comb begin
    rd_o   = 1'b0;
    wr_o   = 1'b0;
    addr_o = waddr;
    if (last_bit) begin
      unique case (ph)
        PH_ADDR: if (!is_wr) begin
          rd_o   = 1'b1;
          addr_o = is_burst ? ADDR_W'(BURST_FIRST) : byte_w[ADDR_W-1:0];
        end
        PH_WDATA: wr_o = 1'b1;
        PH_BURST: begin
          rd_o   = 1'b1;
          addr_o = ADDR_W'(BURST_FIRST) + ADDR_W'(nidx);
        end
        default: ;
      endcase
    end
  end

  assign wdata_o = byte_w;
  assign phase_o = ph;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph    <= PH_ADDR;
      bcnt  <= '0;
      shin  <= '0;
      waddr <= '0;
      bidx  <= '0;
    end else if (!active_i) begin
      ph   <= PH_ADDR;
      bcnt <= '0;
      bidx <= '0;
    end else if (rise_i) begin
      shin <= byte_w;
      bcnt <= last_bit ? '0 : bcnt + 1'b1;
      if (last_bit) begin
        unique case (ph)
          PH_ADDR: begin
            if (is_wr) begin
              ph    <= PH_WDATA;
              waddr <= byte_w[ADDR_W-1:0];
            end else if (is_burst) begin
              ph   <= PH_BURST;
              bidx <= '0;
            end else begin
              ph <= PH_RDATA;
            end
          end
          PH_WDATA, PH_RDATA: ph <= PH_ADDR;
          PH_BURST: bidx <= nidx;
          default: ph <= PH_ADDR;
        endcase
      end
    end
  end
endmodule

// File: rtl/sio_tx.sv
module sio_tx #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic              fall_i,
  input  logic              drive_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] ldata_i,
  output logic              dout_o,
  output logic              oe_o
);
  logic [DATA_W-1:0] sh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh     <= '0;
      dout_o <= 1'b0;
      oe_o   <= 1'b0;
    end else if (!active_i) begin
      sh     <= '0;
      dout_o <= 1'b0;
      oe_o   <= 1'b0;
    end else if (load_i) begin
      sh <= ldata_i;
    end else if (fall_i) begin
      if (drive_i) begin
        oe_o   <= 1'b1;
        dout_o <= sh[DATA_W-1];
        sh     <= {sh[DATA_W-2:0], 1'b0};
      end else begin
        oe_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sio_port.sv
module sio_port
  import sio_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter int         DATA_W      = 8,
  parameter int         BURST_LEN   = 7,
  parameter logic [6:0] BURST_CMD   = 7'h63,
  parameter logic [6:0] BURST_FIRST = 7'h03,
  localparam int        ADDR_W      = DATA_W - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              sel_n_i,
  input  logic              sdio_i,
  output logic              sdio_o,
  output logic              sdio_oe_o,
  output logic              reg_rd_o,
  output logic              reg_wr_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  input  logic [DATA_W-1:0] reg_rdata_i
);
  logic   sclk_rise;
  logic   sclk_fall;
  logic   active;
  logic   sdio_s;
  logic   oe_q;
  logic   drive;
  phase_e phase;

  sio_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sclk_i   (sclk_i),
    .sel_n_i  (sel_n_i),
    .sdio_i   (sdio_i),
    .rise_o   (sclk_rise),
    .fall_o   (sclk_fall),
    .active_o (active),
    .sdio_o   (sdio_s)
  );

  sio_frame #(
    .DATA_W      (DATA_W),
    .BURST_LEN   (BURST_LEN),
    .BURST_CMD   (BURST_CMD),
    .BURST_FIRST (BURST_FIRST)
  ) u_frame (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (active),
    .rise_i   (sclk_rise),
    .sdio_i   (sdio_s),
    .phase_o  (phase),
    .rd_o     (reg_rd_o),
    .wr_o     (reg_wr_o),
    .addr_o   (reg_addr_o),
    .wdata_o  (reg_wdata_o)
  );

  assign drive = (phase == PH_RDATA) || (phase == PH_BURST);

  sio_tx #(.DATA_W(DATA_W)) u_tx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (active),
    .fall_i   (sclk_fall),
    .drive_i  (drive),
    .load_i   (reg_rd_o),
    .ldata_i  (reg_rdata_i),
    .dout_o   (sdio_o),
    .oe_o     (oe_q)
  );

  // release the line straight from the raw select, ahead of the synchroniser
  assign sdio_oe_o = oe_q & ~sel_n_i;
endmodule

// File: rtl/sio_port_chk.sv
module sio_port_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic sel_n_i,
  input logic sdio_o,
  input logic sdio_oe_o,
  input logic reg_rd_o,
  input logic reg_wr_o,
  input logic sclk_rise,
  input logic sclk_fall
);
  p_strobe_on_rise_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_o || reg_rd_o) |-> sclk_rise);

  p_wr_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_o |=> !reg_wr_o);

  p_out_on_fall_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sdio_oe_o && $past(sdio_oe_o) && (sdio_o != $past(sdio_o))) |-> $past(sclk_fall));

  p_oe_deselect_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_n_i |-> !sdio_oe_o);

  p_rd_wr_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_wr_o && reg_rd_o));
endmodule

bind sio_port sio_port_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sel_n_i   (sel_n_i),
  .sdio_o    (sdio_o),
  .sdio_oe_o (sdio_oe_o),
  .reg_rd_o  (reg_rd_o),
  .reg_wr_o  (reg_wr_o),
  .sclk_rise (sclk_rise),
  .sclk_fall (sclk_fall)
);

// File: tb/sio_port_bench.sv
module sio_port_bench;
  localparam int HALF = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sclk = 1'b1;
  logic       sel_n = 1'b1;
  logic       sdio = 1'b0;
  logic       sdio_o, sdio_oe_o, reg_rd_o, reg_wr_o;
  logic [6:0] reg_addr_o;
  logic [7:0] reg_wdata_o, reg_rdata_i;

  int n_chk = 0, n_err = 0;
  int wr_cnt = 0, rd_cnt = 0;
  logic [6:0] wr_a;
  logic [7:0] wr_d;
  bit done = 0;

  always #10 clk = ~clk;

  function automatic logic [7:0] reg_val(input logic [6:0] a);
    return {a, 1'b0} ^ 8'h5A;
  endfunction

  assign reg_rdata_i = reg_val(reg_addr_o);

  sio_port u_sio_port (
    .clk_i (clk), .rst_ni (rst_n), .sclk_i (sclk), .sel_n_i (sel_n), .sdio_i (sdio),
    .sdio_o (sdio_o), .sdio_oe_o (sdio_oe_o), .reg_rd_o (reg_rd_o), .reg_wr_o (reg_wr_o),
    .reg_addr_o (reg_addr_o), .reg_wdata_o (reg_wdata_o), .reg_rdata_i (reg_rdata_i)
  );

  always @(negedge clk) begin
    if (reg_wr_o) begin wr_cnt++; wr_a = reg_addr_o; wr_d = reg_wdata_o; end
    if (reg_rd_o) rd_cnt++;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic sel_low();
    @(negedge clk); sel_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic sel_high();
    repeat (HALF) @(negedge clk);
    sel_n = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  // n clock periods; drives d MSB first, captures the slave output before each rising edge
  task automatic do_bits(input int n, input logic drv, input logic [7:0] d,
                         output logic [7:0] q, output logic oe_hi, output logic oe_lo);
    q = '0; oe_hi = 1'b1; oe_lo = 1'b1;
    for (int i = 7; i > 7 - n; i--) begin
      @(negedge clk); sclk = 1'b0;
      if (drv) sdio = d[i];
      repeat (HALF) @(negedge clk);
      q = {q[6:0], sdio_o};
      if (sdio_oe_o) oe_lo = 1'b0; else oe_hi = 1'b0;
      sclk = 1'b1;
      repeat (HALF - 1) @(negedge clk);
    end
  endtask

  task automatic write_frame(input logic [6:0] a, input logic [7:0] d);
    logic [7:0] q; logic h, l;
    sel_low();
    do_bits(8, 1'b1, {1'b1, a}, q, h, l);
    do_bits(8, 1'b1, d, q, h, l);
    sel_high();
  endtask

  initial begin
    logic [7:0] q, exp;
    logic h, l, h2, l2;
    int w0, r0;

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!sdio_oe_o && !reg_wr_o && !reg_rd_o && wr_cnt == 0 && rd_cnt == 0,
          "R1 reset idle", {sdio_oe_o, reg_wr_o, reg_rd_o}, 0);

    // R2 write sweep over all addresses
    for (int a = 0; a < 128; a++) begin
      w0 = wr_cnt; r0 = rd_cnt;
      write_frame(7'(a), 8'(a * 37 + 5));
      check(wr_cnt == w0 + 1 && rd_cnt == r0 && wr_a == 7'(a) && wr_d == 8'(a * 37 + 5),
            "R2 write frame", {wr_a, wr_d}, {7'(a), 8'(a * 37 + 5)});
    end

    // R3/R4 read sweep over all non-burst addresses
    for (int a = 0; a < 128; a++) begin
      if (a == 'h63) continue;
      w0 = wr_cnt; r0 = rd_cnt;
      sel_low();
      do_bits(8, 1'b1, {1'b0, 7'(a)}, q, h, l);
      do_bits(8, 1'b0, 8'h00, q, h2, l2);
      exp = reg_val(7'(a));
      check(q == exp && rd_cnt == r0 + 1 && wr_cnt == w0, "R3 read frame", q, exp);
      check(l && h2, "R4 oe low in address, high in data", {l, h2}, 2'b11);
      sel_high();
      check(!sdio_oe_o, "R4 oe after select", sdio_oe_o, 0);
    end

    // R4 oe drops at the falling edge after a read frame ends, select still low
    sel_low();
    do_bits(8, 1'b1, 8'h11, q, h, l);
    do_bits(8, 1'b0, 8'h00, q, h, l);
    do_bits(1, 1'b1, 8'h00, q, h, l);
    check(l, "R4 oe released after frame end", h, 0);
    sel_high();

    // R5 abort mid-write: no write strobe
    w0 = wr_cnt;
    sel_low();
    do_bits(8, 1'b1, 8'h85, q, h, l);
    do_bits(3, 1'b1, 8'hFF, q, h, l);
    sel_high();
    check(wr_cnt == w0, "R5 aborted write discarded", wr_cnt - w0, 0);
    // R5 abort mid-address then a full write decodes from its first bit
    sel_low();
    do_bits(4, 1'b1, 8'hE3, q, h, l);
    sel_high();
    write_frame(7'h2C, 8'h9D);
    check(wr_cnt == w0 + 1 && wr_a == 7'h2C && wr_d == 8'h9D, "R5 next frame after abort",
          {wr_a, wr_d}, {7'h2C, 8'h9D});

    // R6 activity with select high
    w0 = wr_cnt; r0 = rd_cnt;
    do_bits(8, 1'b1, 8'h85, q, h, l);
    do_bits(8, 1'b1, 8'h3C, q, h2, l2);
    check(wr_cnt == w0 && rd_cnt == r0 && l && l2, "R6 ignored while deselected",
          wr_cnt - w0 + rd_cnt - r0, 0);

    // R7/R8/R9 burst
    w0 = wr_cnt;
    sel_low();
    do_bits(8, 1'b1, 8'h63, q, h, l);
    for (int k = 0; k < 10; k++) begin
      do_bits(8, 1'b1, (k >= 8) ? 8'h85 : 8'h00, q, h, l);
      exp = reg_val(7'(3 + ((k < 6) ? k : 6)));
      if (k < 7) check(q == exp && h, "R7 burst order", q, exp);
      else       check(q == exp && h, "R8 burst repeats last", q, exp);
    end
    check(wr_cnt == w0, "R9 no write inside burst", wr_cnt - w0, 0);
    sel_high();
    write_frame(7'h05, 8'h33);
    check(wr_cnt == w0 + 1 && wr_a == 7'h05 && wr_d == 8'h33, "R9 port usable after deselect",
          {wr_a, wr_d}, {7'h05, 8'h33});

    // R7 short burst ended after the first byte, then a normal read
    sel_low();
    do_bits(8, 1'b1, 8'h63, q, h, l);
    do_bits(8, 1'b0, 8'h00, q, h, l);
    check(q == reg_val(7'h03), "R7 first burst byte", q, reg_val(7'h03));
    sel_high();
    sel_low();
    do_bits(8, 1'b1, 8'h40, q, h, l);
    do_bits(8, 1'b0, 8'h00, q, h, l);
    check(q == reg_val(7'h40), "R3 read after burst", q, reg_val(7'h40));
    sel_high();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule